// File: doc/BRIEF.md
# TDM Transmit Slot Sequencer

This block drives one transmit lane of a time-division-multiplexed serial line. A frame is divided into a programmable number of slots, up to 32. A 32-bit enable mask marks the slots this device owns. The block counts bit-clock strobes from each frame sync to track the current slot. It keeps a one-word holding buffer that an external DMA engine refills. It also keeps a shift register that sends the word out MSB first, one bit per bit strobe.

Each active slot needs a refill from the DMA engine. To give the engine time, the block raises a one-cycle data request one slot ahead of each active slot. The request is timed off the start of the slot just before that active slot, whether that earlier slot is active or not. In slots the device does not own, the pin follows a programmable idle mode: released (high impedance), driven 0 or driven 1. Raising `enable` starts an initialization period. A priming request fills the buffer before the first frame sync. If an active slot begins with an empty buffer, zeros are sent and a sticky underrun flag is set.

Top module: `tdm_tx_slot_seq`

## Requirements
- R1: On a `bitTick` with `frameSync` high, the slot count restarts at slot 0, bit 0, even partway through a frame. Otherwise the count moves to the next slot after every SLOT_W bit ticks. After slot `lastSlot` it wraps to slot 0.
- R2: In a slot whose bit in `slotMask` is 1, the word taken from the holding buffer at slot start appears on `txData`, MSB first, with `txOe` = 1. Bit k of the slot is visible from the clock after the k-th bit tick of the slot (counting from 0) until the next bit tick.
- R3: In a slot whose mask bit is 0, the holding buffer is left untouched and no word is consumed. `idleMode` sets the output: 0 or 3 gives `txOe` = 0 and `txData` = 0; 1 gives `txOe` = 1 and `txData` = 0; 2 gives `txOe` = 1 and `txData` = 1.
- R4: `dataReq` pulses in the clock after the bit tick that starts slot S when all of the following hold: the slot after S is enabled (slot 0 follows `lastSlot`), and the holding buffer is empty once that tick's copy is done. No request is raised at any other bit tick.
- R5: Every `dataReq` pulse lasts exactly one clock.
- R6: In the clock after `enable` rises, one priming `dataReq` is raised. Until the first frame sync, the pin stays in its idle mode.
- R7: If an active slot starts with an empty holding buffer, zeros are shifted out for that slot and `underrun` goes to 1. It stays at 1 while `enable` stays high.
- R8: A buffer write in the same clock as a slot-start copy does not reach the word being copied. The write is kept for the next active slot.
- R9: While `enable` is low, or in reset, the block holds these values: buffer empty, `underrun` = 0, `dataReq` = 0, no slot active, and the pin in its idle mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmit enable; low clears the sequencer |
| bitTick | input | 1 | One-clock strobe per serial bit time |
| frameSync | input | 1 | Frame start, qualified by `bitTick` |
| lastSlot | input | $clog2(MAX_SLOTS) | Index of the final slot in a frame (slots minus one) |
| slotMask | input | MAX_SLOTS | Per-slot enable, bit i for slot i |
| idleMode | input | 2 | Pin behaviour in disabled slots |
| wrValid | input | 1 | Holding-buffer write strobe |
| wrData | input | SLOT_W | Holding-buffer write data |
| txData | output | 1 | Serial data out |
| txOe | output | 1 | Output enable for the serial pin |
| dataReq | output | 1 | One-clock refill request to the DMA engine |
| underrun | output | 1 | Sticky empty-buffer flag |

## Verification
Two events can land in the same clock: a DMA write to the holding buffer and the slot-start copy from that buffer into the shifter. The bench provokes this on purpose. It withholds the normal refill and then writes a word exactly on the bit tick that opens the next active slot. The result passes if that slot sends zeros and raises the underrun flag, the look-ahead request still fires, and the late word comes out intact in the following active slot.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  // Strobes from slot control to the data path
  typedef struct packed {
    logic loadWord;    // copy holding buffer into shifter this clock
    logic shiftBit;    // advance shifter by one bit
    logic slotActive;  // current slot belongs to this device
  } txStrobes_t;

  // Pin behaviour in slots not owned by this device
  typedef enum logic [1:0] {
    IDLE_RELEASE = 2'd0,
    IDLE_LOW     = 2'd1,
    IDLE_HIGH    = 2'd2,
    IDLE_SPARE   = 2'd3
  } idleMode_e;

endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int MAX_SLOTS = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enable,
  input  logic                         bitTick,
  input  logic                         frameSync,
  input  logic [$clog2(MAX_SLOTS)-1:0] lastSlot,
  input  logic [MAX_SLOTS-1:0]         slotMask,
  input  logic                         bufFull,
  output txStrobes_t                   strobes,
  output logic                         dataReq
);

  localparam int BIT_CW  = $clog2(SLOT_W);
  localparam int SLOT_CW = $clog2(MAX_SLOTS);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(SLOT_W - 1);

  logic               enPrev;
  logic               running;
  logic               slotActive;
  logic [BIT_CW-1:0]  bitCnt;
  logic [SLOT_CW-1:0] slotCnt;

  logic               slotStart;
  logic               loadNow;
  logic               shiftNow;
  logic               lookReq;
  logic               primeReq;
  logic [SLOT_CW-1:0] newSlot;
  logic [SLOT_CW-1:0] peekSlot;

  // Successor in the frame, wrapping after the programmed last slot
  function automatic logic [SLOT_CW-1:0] stepSlot(input logic [SLOT_CW-1:0] cur,
                                                  input logic [SLOT_CW-1:0] last);
    return (cur == last) ? '0 : cur + 1'b1;
  endfunction

  always_comb begin
    slotStart = enable && bitTick && (frameSync || (running && bitCnt == LAST_BIT));
    newSlot   = frameSync ? '0 : stepSlot(slotCnt, lastSlot);
    peekSlot  = stepSlot(newSlot, lastSlot);
    loadNow   = slotStart && slotMask[newSlot];
    shiftNow  = enable && running && bitTick && !slotStart;
    // Look-ahead: ask for the next slot's word only if the buffer will be empty
    lookReq   = slotStart && slotMask[peekSlot] && (!bufFull || loadNow);
    primeReq  = enable && !enPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev     <= 1'b0;
      running    <= 1'b0;
      slotActive <= 1'b0;
      bitCnt     <= '0;
      slotCnt    <= '0;
      dataReq    <= 1'b0;
    end else if (!enable) begin
      enPrev     <= 1'b0;
      running    <= 1'b0;
      slotActive <= 1'b0;
      bitCnt     <= '0;
      slotCnt    <= '0;
      dataReq    <= 1'b0;
    end else begin
      enPrev  <= 1'b1;
      dataReq <= primeReq || lookReq;
      if (slotStart) begin
        running    <= 1'b1;
        slotCnt    <= newSlot;
        bitCnt     <= '0;
        slotActive <= slotMask[newSlot];
      end else if (shiftNow) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.loadWord   = loadNow;
    strobes.shiftBit   = shiftNow;
    strobes.slotActive = slotActive;
  end

endmodule

// File: rtl/tdm_tx_dp.sv
module tdm_tx_dp
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  txStrobes_t        strobes,
  input  logic              wrValid,
  input  logic [SLOT_W-1:0] wrData,
  input  logic [1:0]        idleMode,
  output logic              bufFull,
  output logic              txData,
  output logic              txOe,
  output logic              underrun
);

  logic [SLOT_W-1:0] holdBuf;
  logic [SLOT_W-1:0] shifter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdBuf  <= '0;
      shifter  <= '0;
      bufFull  <= 1'b0;
      underrun <= 1'b0;
    end else if (!enable) begin
      holdBuf  <= '0;
      shifter  <= '0;
      bufFull  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      // Copy uses the old buffer contents; a same-clock write lands afterwards
      if (strobes.loadWord) begin
        shifter <= bufFull ? holdBuf : '0;
        if (!bufFull) underrun <= 1'b1;
      end else if (strobes.shiftBit) begin
        shifter <= {shifter[SLOT_W-2:0], 1'b0};
      end

      if (wrValid) begin
        holdBuf <= wrData;
        bufFull <= 1'b1;
      end else if (strobes.loadWord) begin
        bufFull <= 1'b0;
      end
    end
  end

  always_comb begin
    if (strobes.slotActive) begin
      txData = shifter[SLOT_W-1];
      txOe   = 1'b1;
    end else begin
      unique case (idleMode_e'(idleMode))
        IDLE_LOW:  begin txData = 1'b0; txOe = 1'b1; end
        IDLE_HIGH: begin txData = 1'b1; txOe = 1'b1; end
        default:   begin txData = 1'b0; txOe = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/tdm_tx_slot_seq.sv
module tdm_tx_slot_seq
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int MAX_SLOTS = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enable,
  input  logic                         bitTick,
  input  logic                         frameSync,
  input  logic [$clog2(MAX_SLOTS)-1:0] lastSlot,
  input  logic [MAX_SLOTS-1:0]         slotMask,
  input  logic [1:0]                   idleMode,
  input  logic                         wrValid,
  input  logic [SLOT_W-1:0]            wrData,
  output logic                         txData,
  output logic                         txOe,
  output logic                         dataReq,
  output logic                         underrun
);

  txStrobes_t strobes;
  logic       bufFull;

  tdm_tx_ctrl #(
    .SLOT_W   (SLOT_W),
    .MAX_SLOTS(MAX_SLOTS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .bitTick  (bitTick),
    .frameSync(frameSync),
    .lastSlot (lastSlot),
    .slotMask (slotMask),
    .bufFull  (bufFull),
    .strobes  (strobes),
    .dataReq  (dataReq)
  );

  tdm_tx_dp #(
    .SLOT_W(SLOT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .strobes (strobes),
    .wrValid (wrValid),
    .wrData  (wrData),
    .idleMode(idleMode),
    .bufFull (bufFull),
    .txData  (txData),
    .txOe    (txOe),
    .underrun(underrun)
  );

endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic bitTick,
  input logic txData,
  input logic txOe,
  input logic dataReq,
  input logic underrun
);

  // Released pin never carries a one
  p_release_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> !txData);

  // Look-ahead requests follow a bit tick; the priming one follows enable rising
  p_req_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && $past(enable, 2)) |-> $past(bitTick));

  // Pin holds between bit ticks while running
  p_pin_steady_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !bitTick) |=> ($stable(txData) && $stable(txOe)));

  // Underrun sticks while enabled
  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && underrun) |=> (underrun || !enable));

  // Disable clears request and flag
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!dataReq && !underrun));

endmodule

bind tdm_tx_slot_seq tdm_tx_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .bitTick (bitTick),
  .txData  (txData),
  .txOe    (txOe),
  .dataReq (dataReq),
  .underrun(underrun)
);

// File: tb/test_tdm_tx_slot_seq.sv
module test_tdm_tx_slot_seq;

  localparam int W  = 8;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          enable;
  logic          bitTick;
  logic          frameSync;
  logic [4:0]    lastSlot;
  logic [NS-1:0] slotMask;
  logic [1:0]    idleMode;
  logic          wrValid;
  logic [W-1:0]  wrData;
  logic          txData;
  logic          txOe;
  logic          dataReq;
  logic          underrun;

  always #10 clk = ~clk;  // 50 MHz

  tdm_tx_slot_seq #(.SLOT_W(W), .MAX_SLOTS(NS)) i_tdm_tx_slot_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
    .frameSync(frameSync), .lastSlot(lastSlot), .slotMask(slotMask),
    .idleMode(idleMode), .wrValid(wrValid), .wrData(wrData),
    .txData(txData), .txOe(txOe), .dataReq(dataReq), .underrun(underrun)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  // Bench model of the buffer contents, as stated in the requirements
  logic         expFull;
  logic [W-1:0] expBuf;
  logic [W-1:0] expShift;
  logic         expUnder;
  int           wrCount;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] wordVal(input int k);
    return W'((k * 29 + 3) ^ 8'h5A);
  endfunction

  function automatic logic idleOe(input logic [1:0] m);
    return (m == 2'd1) || (m == 2'd2);
  endfunction

  // One bit time: tick clock then idle clock; returns at the idle-clock negedge
  task automatic doBit(input logic fs, input logic wrTick, input logic [W-1:0] tickData);
    @(negedge clk);
    bitTick = 1'b1; frameSync = fs; wrValid = wrTick; wrData = tickData;
    @(negedge clk);
    bitTick = 1'b0; frameSync = 1'b0; wrValid = 1'b0;
  endtask

  task automatic startRun(input logic [NS-1:0] mask, input int last,
                          input logic [1:0] mode, input bit respond);
    @(negedge clk);
    enable = 1'b0; wrValid = 1'b0;
    slotMask = mask; lastSlot = 5'(last); idleMode = mode;
    @(negedge clk);
    check("R9", "underrun off", 32'(underrun), 32'd0);
    check("R9", "dataReq off", 32'(dataReq), 32'd0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R6", "prime request", 32'(dataReq), 32'd1);
    expFull = 1'b0; expUnder = 1'b0; expShift = '0; wrCount = 0;
    if (respond) begin
      wrValid = 1'b1; wrData = wordVal(0);
      expBuf = wordVal(0); expFull = 1'b1; wrCount = 1;
    end
    @(negedge clk);
    wrValid = 1'b0;
    check("R5", "prime pulse width", 32'(dataReq), 32'd0);
    check("R6", "idle before sync oe", 32'(txOe), 32'(idleOe(mode)));
    check("R6", "idle before sync data", 32'(txData), 32'(mode == 2'd2));
  endtask

  task automatic runFrames(input logic [NS-1:0] mask, input int last, input int drive,
                           input logic [1:0] mode, input bit respond, input int frames);
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < drive; s++) begin
        for (int b = 0; b < W; b++) begin
          logic act;
          logic expReq;
          int   nxt;
          act = mask[s];
          nxt = (s == last) ? 0 : s + 1;
          expReq = (b == 0) && mask[nxt] && (!expFull || act);
          if (b == 0 && act) begin
            if (expFull) expShift = expBuf;
            else begin expShift = '0; expUnder = 1'b1; end
            expFull = 1'b0;
          end
          doBit(s == 0 && b == 0, 1'b0, '0);
          if (act) begin
            check("R2", "active oe", 32'(txOe), 32'd1);
            check("R2", "active data", 32'(txData), 32'(expShift[W-1-b]));
          end else begin
            check("R3", "idle oe", 32'(txOe), 32'(idleOe(mode)));
            check("R3", "idle data", 32'(txData), 32'(mode == 2'd2));
          end
          check("R4", "request timing", 32'(dataReq), 32'(expReq));
          check("R7", "underrun flag", 32'(underrun), 32'(expUnder));
          if (dataReq && respond) begin
            wrValid = 1'b1; wrData = wordVal(wrCount);
            expBuf = wordVal(wrCount); expFull = 1'b1; wrCount++;
          end
        end
      end
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; bitTick = 1'b0; frameSync = 1'b0;
    lastSlot = '0; slotMask = '0; idleMode = 2'd0; wrValid = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    check("R9", "reset oe", 32'(txOe), 32'd0);
    check("R9", "reset req", 32'(dataReq), 32'd0);
    check("R9", "reset underrun", 32'(underrun), 32'd0);
    rstN = 1'b1;

    // Sweep every mask of a 4-slot frame under every idle mode (R2, R3, R4)
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 16; k++) begin
        startRun(NS'(k), 3, 2'(m), 1'b1);
        runFrames(NS'(k), 3, 4, 2'(m), 1'b1, 2);
      end
    end

    // Full 32-slot frame, wrap from last slot to slot 0 (R4, R1)
    startRun(32'h8000_0001, 31, 2'd2, 1'b1);
    runFrames(32'h8000_0001, 31, 32, 2'd2, 1'b1, 2);
    startRun(32'hA5A5_0F0F, 31, 2'd1, 1'b1);
    runFrames(32'hA5A5_0F0F, 31, 32, 2'd1, 1'b1, 2);

    // R1: frame sync restarts the count before lastSlot is reached
    startRun(32'h0000_00B6, 7, 2'd1, 1'b1);
    runFrames(32'h0000_00B6, 7, 5, 2'd1, 1'b1, 3);

    // R7: no refills at all, zeros and sticky underrun
    startRun(32'h0000_000A, 3, 2'd0, 1'b0);
    runFrames(32'h0000_000A, 3, 4, 2'd0, 1'b0, 2);

    // R8: write collides with the slot-start copy
    startRun(32'h0000_0007, 3, 2'd2, 1'b1);
    for (int b = 0; b < W; b++) begin
      doBit(b == 0, 1'b0, '0);
      check("R8", "slot0 primed word", 32'(txData), 32'(wordVal(0)[W-1-b]));
    end
    for (int b = 0; b < W; b++) begin
      doBit(1'b0, b == 0, 8'hC3);
      check("R8", "slot1 zeros", 32'(txData), 32'd0);
      check("R8", "slot1 oe", 32'(txOe), 32'd1);
      check("R7", "slot1 underrun", 32'(underrun), 32'd1);
      if (b == 0) check("R4", "slot1 request for slot2", 32'(dataReq), 32'd1);
    end
    for (int b = 0; b < W; b++) begin
      doBit(1'b0, 1'b0, '0);
      check("R8", "slot2 late word", 32'(txData), 32'(8'hC3 >> (W - 1 - b)) & 32'd1);
      if (b == 0) check("R4", "no request for idle slot3", 32'(dataReq), 32'd0);
    end
    doBit(1'b0, 1'b0, '0);
    check("R3", "slot3 driven high", 32'(txData), 32'd1);

    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "disable clears underrun", 32'(underrun), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule